// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single transmit line. A character of up to nine bits is accepted through a valid/ready handshake. The block then drives a low start bit, the data bits, an optional parity bit and one or two high stop bits. The line is high whenever no frame is in progress.

The framing is set by a group of control inputs, captured when the character is accepted. These inputs select the data length (5 to 8 bits, or a forced 9-bit mode), whether a parity bit is sent, even or odd parity, fixed ("stick") parity, the number of stop bits, which end of the data goes first, and whether a bit lasts 8 or 16 pulses of the oversampling tick input. Baud-rate generation is done elsewhere. The tick input is the only time base that paces the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from that edge until the frame ends, and `tx_valid` pulses while busy start no frame.
- R3: A frame consists of a start bit at 0, then the data bits, then the parity bit when `par_en` is 1, then the stop bits at 1.
- R4: With `nine_bit` at 0, `len_sel` values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits, taken from the low bits of `tx_data`.
- R5: With `nine_bit` at 1, the frame carries 9 data bits (`tx_data[8:0]`) whatever `len_sel` holds.
- R6: With `par_en`=1 and `stick`=0, the parity bit makes the count of ones over data plus parity even when `even`=1, and odd when `even`=0.
- R7: With `par_en`=1 and `stick`=1, the parity bit is always 0 when `even`=1 and always 1 when `even`=0.
- R8: With `msb_first`=1, the highest data bit of the selected length goes first. With `msb_first`=0, bit 0 goes first.
- R9: `two_stop`=1 sends two stop bits, and `two_stop`=0 sends one.
- R10: Each frame bit lasts 8 `tick` pulses when `os8`=1 and 16 when `os8`=0. Clock edges without `tick` do not advance the frame.
- R11: The control inputs and data are sampled only at acceptance. Changes to them during a frame do not alter that frame.
- R12: `busy` rises on the acceptance edge and falls on the edge that ends the last stop bit, which is the tick that completes the total bit count times the ticks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling pulse, one clock wide |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can accept a character |
| len_sel | input | 2 | Data length code (5 to 8 bits) |
| nine_bit | input | 1 | Force 9 data bits |
| par_en | input | 1 | Send a parity bit |
| even | input | 1 | Even parity, or stick value 0 |
| stick | input | 1 | Fixed parity value |
| two_stop | input | 1 | Two stop bits |
| msb_first | input | 1 | Most significant data bit first |
| os8 | input | 1 | 8 ticks per bit instead of 16 |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The hardest case to reach is proving that settings captured at acceptance govern the whole frame. It needs inputs that change in the middle of a frame and a late `tx_valid` offered while busy. After every acceptance, the bench inverts all control inputs and the data, and injects a one-cycle `tx_valid` pulse inside the frame. It then checks that the frame still matches the captured settings and that the line stays idle afterwards. One further frame holds `tick` low for a stretch right after acceptance, to show the start bit does not advance without ticks.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DW   = 9,
  parameter int MAXF = DW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [1:0]    len_sel,
  input  logic          nine_bit,
  input  logic          par_en,
  input  logic          even,
  input  logic          stick,
  input  logic          two_stop,
  input  logic          msb_first,
  input  logic          os8,
  output logic          txd,
  output logic          busy
);
  localparam int IW = $clog2(MAXF + 1);

  logic [MAXF-1:0] frame_q, frame_d;
  logic [IW-1:0]   nbits_q, nbits_d, idx_q;
  logic [3:0]      cnt_q;
  logic            os8_q;
  logic [3:0]      ndata;
  logic [DW-1:0]   ord;
  logic            pbit;

  assign tx_ready = !busy;
  assign txd      = busy ? frame_q[idx_q] : 1'b1;
  assign ndata    = nine_bit ? 4'd9 : 4'd5 + {2'b00, len_sel};

  always_comb begin
    ord = '0;
    for (int i = 0; i < DW; i++)
      if (i < int'(ndata))
        ord[i] = msb_first ? tx_data[int'(ndata) - 1 - i] : tx_data[i];
    pbit = stick ? !even : (even ? ^ord : ~^ord);
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < int'(ndata)) frame_d[1 + i] = ord[i];
    if (par_en) frame_d[1 + int'(ndata)] = pbit;
    nbits_d = IW'(ndata) + IW'(2) + IW'(par_en) + IW'(two_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      nbits_q <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      os8_q   <= 1'b0;
    end else if (!busy) begin
      if (tx_valid) begin
        busy    <= 1'b1;
        frame_q <= frame_d;
        nbits_q <= nbits_d;
        idx_q   <= '0;
        cnt_q   <= '0;
        os8_q   <= os8;
      end
    end else if (tick) begin
      if (cnt_q == (os8_q ? 4'd7 : 4'd15)) begin
        cnt_q <= '0;
        if (idx_q == nbits_q - IW'(1)) busy <= 1'b0;
        else idx_q <= idx_q + IW'(1);
      end else begin
        cnt_q <= cnt_q + 4'd1;
      end
    end
  end

  AST_IDLE_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);                     // R1
  AST_ACCEPT:     assert property (@(posedge clk) disable iff (!rst_n) tx_valid && tx_ready |=> busy);     // R2
  AST_START_LOW:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd);              // R3
  AST_NO_TICK:    assert property (@(posedge clk) disable iff (!rst_n) busy && !tick |=> busy && $stable(txd)); // R10
  AST_LAST_STOP:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(txd));        // R12
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic clk = 0, rst_n = 0, tick = 1;
  logic [8:0] tx_data = '0;
  logic tx_valid = 0, nine_bit = 0, par_en = 0, even = 0, stick = 0, two_stop = 0, msb_first = 0, os8 = 0;
  logic [1:0] len_sel = '0;
  logic tx_ready, txd, busy;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_frame_tx uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input logic [1:0] ls, input bit nb, input bit pe,
                      input bit ev, input bit st, input bit ts, input bit mf, input bit o8,
                      input int hold);
    int nd, n, total, pos;
    logic [15:0] expf, got;
    logic [8:0] ordv;
    bit par;
    nd = nb ? 9 : 5 + ls;
    n  = o8 ? 8 : 16;
    ordv = '0;
    for (int i = 0; i < nd; i++) ordv[i] = mf ? d[nd-1-i] : d[i];
    par = 0;
    for (int i = 0; i < nd; i++) par ^= ordv[i];
    if (st) par = !ev; else if (!ev) par = !par;
    expf = '1; expf[0] = 0;
    for (int i = 0; i < nd; i++) expf[1+i] = ordv[i];
    pos = 1 + nd;
    if (pe) begin expf[pos] = par; pos++; end
    total = pos + (ts ? 2 : 1);
    @(negedge clk);
    tx_data = d; len_sel = ls; nine_bit = nb; par_en = pe; even = ev; stick = st;
    two_stop = ts; msb_first = mf; os8 = o8; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    chk(busy && !tx_ready, "R2 accept", {busy, tx_ready}, 2);
    // R11: scramble every input during the frame
    tx_data = ~d; len_sel = ~ls; nine_bit = !nb; par_en = !pe; even = !ev; stick = !st;
    two_stop = !ts; msb_first = !mf; os8 = !o8;
    if (hold > 0) begin
      tick = 0;
      repeat (hold) @(negedge clk);
      chk(busy && !txd, "R10 no tick holds start", {busy, txd}, 2);
      tick = 1;
    end
    got = '1;
    for (int c = 0; c < total * n; c++) begin
      if (c % n == n / 2) got[c / n] = txd;
      if (c == n + 1) tx_valid = 1;
      if (c == n + 2) tx_valid = 0;
      if (!busy) begin
        chk(0, "R12 busy early", c, total * n);
        break;
      end
      @(negedge clk);
    end
    // R3 R4 R5 R6 R7 R8 R9 R11 frame content
    chk(got == expf, "R3-frame(R4 R5 R6 R7 R8 R9 R11)", got, expf);
    chk(!busy && txd && tx_ready, "R12 busy ends after last stop", {busy, txd, tx_ready}, 3);
    repeat (n + 3) @(negedge clk);
    chk(!busy && txd, "R2 busy-time valid ignored", {busy, txd}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd && !busy && tx_ready, "R1 reset idle", {txd, busy, tx_ready}, 5);
    rst_n = 1;
    @(negedge clk);
    chk(txd && !busy && tx_ready, "R1 idle after reset", {txd, busy, tx_ready}, 5);
    send(9'h1A5, 2'd3, 0, 0, 0, 0, 0, 0, 0, 20);  // R10 stalled tick
    for (int l = 0; l < 5; l++)
      for (int pm = 0; pm < 5; pm++)
        for (int ts = 0; ts < 2; ts++)
          for (int mf = 0; mf < 2; mf++)
            for (int o = 0; o < 2; o++)
              for (int dv = 0; dv < 2; dv++)
                send(dv ? 9'h0B3 : 9'h14E, 2'(l), l == 4, pm != 0, pm == 2 || pm == 4,
                     pm >= 3, ts[0], mf[0], o[0], 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule